// File: doc/BRIEF.md
# Transmit Frame Assembler

This block builds one outgoing Ethernet frame at a time from a sequence of 32-bit words written by software. The first word of a frame is a header word. Its low half gives the payload length, which does not count the 14 header bytes. Its high half carries the first two bytes of the frame. Each later word adds four bytes. When enough bytes have arrived, the frame is released on a byte-wide output stream with a valid/ready/last handshake.

Two control inputs shape the frame. When the hardware CRC input is low, software must append its own 4-byte CRC; the block expects those 4 extra bytes and then strips them, because a downstream stage computes the real check sequence. When the pad input is high, a frame shorter than 60 bytes is extended with zero bytes up to 60. A length above the maximum is refused with a one-cycle error pulse. The block then ignores data words until software acknowledges the error. When a frame has been sent, a one-cycle done pulse is raised.

Top module: `tx_frame_assembler`

## Requirements
- R1: After reset, wr_ready is 1 and out_valid, tx_done and tx_err are 0.
- R2: In the idle state a write whose bits 15:0 exceed 2032 is rejected. tx_err is 1 for exactly the one cycle after the write and no frame is produced. A length of exactly 2032 is accepted.
- R3: After a rejected length, data writes are ignored and nothing is emitted until err_clear is sampled high. The next write after that is decoded as a length.
- R4: Bits 23:16 and 31:24 of the header word become frame bytes 0 and 1. Each later word supplies four consecutive bytes, bits 7:0 first, then 15:8, 23:16 and 31:24.
- R5: With hw_crc_en sampled as 1, the frame completes once length + 14 bytes have arrived, and all length + 14 bytes are emitted.
- R6: With hw_crc_en sampled as 0, the frame completes once length + 18 bytes have arrived. The last 4 of those bytes are dropped, so length + 14 bytes are emitted.
- R7: With pad_en sampled as 1 and fewer than 60 bytes to emit, zero bytes follow the data until 60 bytes have been emitted. Frames of 60 bytes or more, and all frames with pad_en 0, are not padded.
- R8: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values. out_last is 1 only on the final byte of the frame.
- R9: wr_ready is 0 from the cycle after the completing write until the last byte is accepted. A write presented in that window is not taken and does not change the frame being emitted.
- R10: tx_done is 1 for exactly the one cycle after the last byte is accepted, and the block is then idle and ready for a new length.
- R11: err_clear sampled high while a frame is being filled discards the partial frame and returns the block to idle. A write in that same cycle is dropped, and tx_err stays 0.
- R12: hw_crc_en and pad_en are sampled only with the header word. Changing them while the frame fills does not change that frame.
- R13: With a 2048-byte store, a maximum length of 2032 and hw_crc_en 0, the 2046 data bytes are emitted intact. The two CRC bytes beyond the store's capacity are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_crc_en | input | 1 | 1: no software CRC bytes in the written data |
| pad_en | input | 1 | 1: pad short frames with zeros to 60 bytes |
| wr_valid | input | 1 | Data word presented |
| wr_data | input | 32 | Data word (header word or four frame bytes) |
| wr_ready | output | 1 | Word accepted when wr_valid and wr_ready are both 1 |
| err_clear | input | 1 | Acknowledge of the transmit error; also aborts a partial frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Marks the final byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |
| tx_done | output | 1 | One-cycle pulse after a frame is fully emitted |
| tx_err | output | 1 | One-cycle pulse after a rejected length |

## Verification
Two functions meet in one cycle: the acknowledge (err_clear) and a data write. The bench raises both together twice. The first time is while a frame is half filled. The second is while the block sits in the error state. In both cases it then sends a fresh frame with a different byte pattern. The output must carry exactly that new pattern with the expected length and no tx_err pulse. If the block had kept the old fill count or taken the simultaneous word, the new frame's bytes or length would be shifted.

// File: rtl/txa_pkg.sv
package txa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2,
    ST_ERR  = 2'd3
  } txa_state_e;

  localparam int HDR_BYTES  = 14;
  localparam int CRC_BYTES  = 4;
  localparam int MIN_FRAME  = 60;
  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/txa_len_decode.sv
module txa_len_decode
  import txa_pkg::*;
#(
  parameter int MAX_LEN = 2032,
  parameter int CW      = 12
) (
  input  logic [15:0]   len_field,
  input  logic          hw_crc,
  output logic          too_long,
  output logic [CW-1:0] data_len,
  output logic [CW-1:0] target_len
);

  logic [CW-1:0] len_trunc;

  always_comb begin
    too_long   = ({16'd0, len_field} > 32'(MAX_LEN));
    len_trunc  = len_field[CW-1:0];
    data_len   = len_trunc + CW'(HDR_BYTES);
    target_len = hw_crc ? data_len : (data_len + CW'(CRC_BYTES));
  end

endmodule

// File: rtl/txa_buffer.sv
module txa_buffer
  import txa_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int CW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic [CW-1:0] wr_base,
  input  logic [31:0]   wr_word,
  input  logic [CW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);

  logic [7:0] mem [DEPTH];

  logic [31:0]                   lane_src;
  logic [WORD_BYTES-1:0][CW-1:0] lane_addr;
  logic [WORD_BYTES-1:0][7:0]    lane_data;
  logic [WORD_BYTES-1:0]         lane_en;

  // header word: only its upper half holds frame bytes, placed at 0 and 1
  assign lane_src = wr_first ? {16'h0000, wr_word[31:16]} : wr_word;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lane_addr[g] = wr_first ? CW'(g) : (wr_base + CW'(g));
    assign lane_data[g] = lane_src[8*g +: 8];
    assign lane_en[g]   = wr_en && (!wr_first || (g < 2)) &&
                          (lane_addr[g] < CW'(DEPTH));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (lane_en[i]) mem[lane_addr[i][AW-1:0]] <= lane_data[i];
    end
  end

  assign rd_byte = (rd_addr < CW'(DEPTH)) ? mem[rd_addr[AW-1:0]] : 8'h00;

endmodule

// File: rtl/txa_ctrl.sv
module txa_ctrl
  import txa_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          err_clear,
  input  logic          too_long,
  input  logic [CW-1:0] data_len_in,
  input  logic [CW-1:0] target_in,
  output logic          buf_wr_en,
  output logic          buf_wr_first,
  output logic [CW-1:0] buf_wr_base,
  output logic [CW-1:0] rd_addr,
  input  logic [7:0]    rd_byte,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          tx_done,
  output logic          tx_err
);

  txa_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] target_q, dlen_q, elen_q;
  logic [CW-1:0] elen_d;
  logic          done_q, done_d, err_q, err_d;
  logic          accept, frame_load, cnt_en, idx_en;
  logic [CW-1:0] cnt_plus;

  assign wr_ready = (state_q != ST_SEND);
  assign accept   = wr_valid && wr_ready;
  assign cnt_plus = cnt_q + CW'(WORD_BYTES);

  assign out_valid = (state_q == ST_SEND);
  assign rd_addr   = idx_q;
  assign out_data  = (idx_q < dlen_q) ? rd_byte : 8'h00;
  assign out_last  = out_valid && (idx_q == (elen_q - CW'(1)));

  assign buf_wr_base = cnt_q;
  assign tx_done     = done_q;
  assign tx_err      = err_q;

  always_comb begin
    elen_d = (pad_en && (data_len_in < CW'(MIN_FRAME))) ? CW'(MIN_FRAME) : data_len_in;
  end

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    idx_d        = idx_q;
    done_d       = 1'b0;
    err_d        = 1'b0;
    buf_wr_en    = 1'b0;
    buf_wr_first = 1'b0;
    frame_load   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (too_long) begin
            state_d = ST_ERR;
            err_d   = 1'b1;
          end else begin
            state_d      = ST_FILL;
            cnt_d        = CW'(2);
            frame_load   = 1'b1;
            buf_wr_en    = 1'b1;
            buf_wr_first = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (err_clear) begin
          state_d = ST_IDLE;
        end else if (accept) begin
          buf_wr_en = 1'b1;
          cnt_d     = cnt_plus;
          if (cnt_plus >= target_q) begin
            state_d = ST_SEND;
            idx_d   = '0;
          end
        end
      end
      ST_SEND: begin
        if (out_ready) begin
          idx_d = idx_q + CW'(1);
          if (out_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_ERR: begin
        if (err_clear) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (cnt_d != cnt_q);
  assign idx_en = (idx_d != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      dlen_q   <= '0;
      elen_q   <= '0;
    end else if (frame_load) begin
      target_q <= target_in;
      dlen_q   <= data_len_in;
      elen_q   <= elen_d;
    end
  end

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (tx_done && !out_valid && wr_ready));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> $past(wr_valid && too_long && (state_q == ST_IDLE)));

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ERR) && !err_clear) |=> ((state_q == ST_ERR) && !out_valid && !tx_done));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> (cnt_q < target_q));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FILL) && err_clear) |=> ((state_q == ST_IDLE) && !tx_err && !out_valid));

endmodule

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler
  import txa_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int MAX_LEN = 2032,
  localparam int SPAN   = MAX_LEN + HDR_BYTES + CRC_BYTES + 2 * WORD_BYTES,
  localparam int CW_A   = $clog2(SPAN),
  localparam int CW_B   = $clog2(DEPTH + 1),
  localparam int CW     = (CW_A > CW_B) ? CW_A : CW_B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_crc_en,
  input  logic        pad_en,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  input  logic        err_clear,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        tx_done,
  output logic        tx_err
);

  logic          too_long;
  logic [CW-1:0] data_len, target_len;
  logic          buf_wr_en, buf_wr_first;
  logic [CW-1:0] buf_wr_base, rd_addr;
  logic [7:0]    rd_byte;

  txa_len_decode #(.MAX_LEN(MAX_LEN), .CW(CW)) u_dec (
    .len_field  (wr_data[15:0]),
    .hw_crc     (hw_crc_en),
    .too_long   (too_long),
    .data_len   (data_len),
    .target_len (target_len)
  );

  txa_buffer #(.DEPTH(DEPTH), .CW(CW)) u_buf (
    .clk      (clk),
    .wr_en    (buf_wr_en),
    .wr_first (buf_wr_first),
    .wr_base  (buf_wr_base),
    .wr_word  (wr_data),
    .rd_addr  (rd_addr),
    .rd_byte  (rd_byte)
  );

  txa_ctrl #(.CW(CW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_en       (pad_en),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .err_clear    (err_clear),
    .too_long     (too_long),
    .data_len_in  (data_len),
    .target_in    (target_len),
    .buf_wr_en    (buf_wr_en),
    .buf_wr_first (buf_wr_first),
    .buf_wr_base  (buf_wr_base),
    .rd_addr      (rd_addr),
    .rd_byte      (rd_byte),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_last     (out_last),
    .out_ready    (out_ready),
    .tx_done      (tx_done),
    .tx_err       (tx_err)
  );

endmodule

// File: tb/tx_frame_assembler_test.sv
module tx_frame_assembler_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_crc_en, pad_en, wr_valid, err_clear, out_ready;
  logic [31:0] wr_data;
  logic        wr_ready, out_valid, out_last, tx_done, tx_err;
  logic [7:0]  out_data;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tx_frame_assembler uut (
    .clk(clk), .rst_n(rst_n), .hw_crc_en(hw_crc_en), .pad_en(pad_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .err_clear(err_clear), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready), .tx_done(tx_done), .tx_err(tx_err)
  );

  localparam int NV = 9;
  localparam int    V_LEN [NV] = '{100, 100, 10, 10, 10, 46, 0, 3, 45};
  localparam bit    V_CRC [NV] = '{1,   0,   1,  1,  0,  1,  0, 0, 1};
  localparam bit    V_PAD [NV] = '{1,   0,   1,  0,  1,  1,  0, 0, 1};
  localparam string V_REQ [NV] = '{"R5", "R6", "R7", "R7", "R7", "R7", "R6", "R4", "R7"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    wr_valid = 1'b1;
    wr_data  = w;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed, input bit crc);
    int tgt;
    tgt = len + 14 + (crc ? 0 : 4);
    wr({8'(seed + 1), 8'(seed), 16'(len)});
    for (int n = 2; n < tgt; n += 4)
      wr({8'(seed + n + 3), 8'(seed + n + 2), 8'(seed + n + 1), 8'(seed + n)});
  endtask

  task automatic collect(input int dlen, input int elen, input int seed,
                         input bit gaps, input string req);
    int idx, bad, cyc;
    bit last_seen, held;
    logic [7:0] hv, e;
    idx = 0; bad = 0; cyc = 0; last_seen = 0; held = 0; hv = '0;
    while (!last_seen && cyc < 5000) begin
      out_ready = gaps ? ((cyc % 3) != 2) : 1'b1;
      #1;
      if (held && out_data !== hv) bad++;  // R8 hold while stalled
      if (out_valid && out_ready) begin
        e = (idx < dlen) ? 8'(seed + idx) : 8'h00;
        if (out_data !== e) bad++;
        if (out_last !== (idx == elen - 1)) bad++;
        last_seen = out_last;
        idx++;
        held = 0;
      end else if (out_valid) begin
        held = 1;
        hv   = out_data;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b1;
    chk(bad == 0, {req, " byte content/last/hold"}, bad, 0);
    chk(idx == elen, {req, " emitted length"}, idx, elen);
    chk(tx_done == 1'b1, "R10 done pulse after last byte", int'(tx_done), 1);
    @(negedge clk);
    chk(tx_done == 1'b0 && wr_ready == 1'b1, "R10 single pulse and idle",
        int'({tx_done, wr_ready}), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_crc_en = 1'b1; pad_en = 1'b0; wr_valid = 1'b0;
    wr_data = '0; err_clear = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(wr_ready == 1'b1 && out_valid == 1'b0 && tx_done == 1'b0 && tx_err == 1'b0,
        "R1 reset outputs", int'({wr_ready, out_valid, tx_done, tx_err}), 8);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      int dl, el, seed;
      hw_crc_en = V_CRC[v];
      pad_en    = V_PAD[v];
      seed      = 16 * v + 3;
      dl        = V_LEN[v] + 14;
      el        = (V_PAD[v] && dl < 60) ? 60 : dl;
      send_frame(V_LEN[v], seed, V_CRC[v]);
      collect(dl, el, seed, v[0], V_REQ[v]);
    end

    // R2 rejected length, R3 ignore in error state, ack together with a write
    hw_crc_en = 1'b1; pad_en = 1'b0;
    wr(32'h0000_07F1);
    chk(tx_err == 1'b1, "R2 error pulse on length 2033", int'(tx_err), 1);
    wr(32'h0000_000A);
    chk(tx_err == 1'b0, "R2 error pulse lasts one cycle", int'(tx_err), 0);
    wr(32'h1111_1111);
    wr(32'h2222_2222);
    for (int k = 0; k < 4; k++) begin
      chk(out_valid == 1'b0 && tx_done == 1'b0, "R3 no output in error state",
          int'({out_valid, tx_done}), 0);
      @(negedge clk);
    end
    err_clear = 1'b1; wr_valid = 1'b1; wr_data = 32'h0000_0003;
    @(negedge clk);
    err_clear = 1'b0; wr_valid = 1'b0;
    send_frame(10, 8'h40, 1'b1);
    collect(24, 24, 8'h40, 1'b0, "R3");

    // R11 abort partial frame with simultaneous write
    wr({8'h11, 8'h10, 16'd100});
    wr(32'hAAAA_AAAA);
    wr(32'hBBBB_BBBB);
    wr(32'hCCCC_CCCC);
    err_clear = 1'b1; wr_valid = 1'b1; wr_data = 32'hDDDD_DDDD;
    @(negedge clk);
    err_clear = 1'b0; wr_valid = 1'b0;
    chk(tx_err == 1'b0 && out_valid == 1'b0, "R11 abort raises no error",
        int'({tx_err, out_valid}), 0);
    send_frame(20, 8'h70, 1'b1);
    collect(34, 34, 8'h70, 1'b1, "R11");

    // R12 controls sampled only with the header word
    hw_crc_en = 1'b1; pad_en = 1'b0;
    wr({8'h56, 8'h55, 16'd10});
    hw_crc_en = 1'b0; pad_en = 1'b1;
    for (int n = 2; n < 24; n += 4)
      wr({8'(8'h55 + n + 3), 8'(8'h55 + n + 2), 8'(8'h55 + n + 1), 8'(8'h55 + n)});
    chk(out_valid == 1'b1, "R12 completion at latched target", int'(out_valid), 1);
    collect(24, 24, 8'h55, 1'b0, "R12");

    // R9 write during output is stalled and has no effect
    hw_crc_en = 1'b1; pad_en = 1'b0;
    out_ready = 1'b0;
    send_frame(10, 8'h90, 1'b1);
    out_ready = 1'b0;
    wr_valid = 1'b1; wr_data = 32'h0000_0005;
    for (int k = 0; k < 3; k++) begin
      chk(wr_ready == 1'b0 && out_valid == 1'b1 && out_data == 8'h90,
          "R9 stalled write during output", int'({wr_ready, out_valid}), 1);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    collect(24, 24, 8'h90, 1'b0, "R9");

    // R13 and R2 boundary: maximum length without hardware CRC
    hw_crc_en = 1'b0; pad_en = 1'b0;
    send_frame(2032, 8'h21, 1'b0);
    collect(2046, 2046, 8'h21, 1'b1, "R13");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule